// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Register

This block holds the combined event status and interrupt mask word of a ten-channel DMA controller. Each channel sends a one-cycle completion pulse that latches a sticky flag. Three controller-wide events also latch sticky flags: a stall, a FIFO that has run empty, and a bus error. Software reads the whole word on a small register bus. To acknowledge an event it writes 1 to that flag bit. To flip a mask bit it writes 1 to that mask bit. Writing a 0 leaves a bit as it is, so one write can acknowledge events and adjust masks without first reading the word.

The block drives one interrupt line. The line is high while some channel flag has its channel mask bit set. It also gives a completion condition for software that polls. This condition takes the channel-enable field of the priority-control value and is true once every enabled channel has its completion flag set. A channel that is not enabled counts as finished.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every register bit reads 0 and `irq_o` is low.
- R2: A pulse on `ch_done_i[n]` sets bit n. A pulse on `stall_evt_i` sets bit 13, on `fifo_empty_evt_i` bit 14, and on `bus_err_evt_i` bit 15. These flags stay set until software clears them.
- R3: A write to the register clears each bit in positions 15:0 whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: A write inverts each mask bit whose write-data bit is 1. The mask bits are 25:16 (channel n at bit 16+n), 29 (stall) and 30 (FIFO empty). Mask bits whose write-data bit is 0 keep their value.
- R5: If a set event and a software clear reach the same flag in the same cycle, the flag ends up set.
- R6: `irq_o` is high exactly when some channel flag n and its mask bit 16+n are both 1. It follows the register contents with no added cycle, so clearing the flag or the mask drops it.
- R7: `all_done_o` is high when every channel n with `pcr_i[n]`=1 has flag n set. Channels with `pcr_i[n]`=0 count as finished, and `pcr_i[31:10]` has no effect.
- R8: Reserved bits 12:10, 28:26 and 31 always read 0, and writing them has no effect.
- R9: A write whose `reg_addr` differs from the register address (default 0x10) changes nothing. A read at any other address returns 0.
- R10: The stall, FIFO-empty and bus-error flags never raise `irq_o`, even when their mask bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 32 | Register bus write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data, combinational on address |
| ch_done_i | input | 10 | Per-channel completion pulses |
| stall_evt_i | input | 1 | Stall event pulse |
| fifo_empty_evt_i | input | 1 | FIFO-empty event pulse |
| bus_err_evt_i | input | 1 | Bus error event pulse |
| pcr_i | input | 32 | Priority-control value; bits 9:0 enable channels |
| irq_o | output | 1 | Interrupt request |
| all_done_o | output | 1 | All enabled channels complete |

## Verification
The first stimulus is the two channels at the ends of the range, 0 and 9, together with the stall event. This shows that each event lands at its own bit index. Clear patterns that mix 1s and 0s show clearing apart from holding. Toggle patterns applied twice show inversion apart from loading. A channel pulse arriving in the same cycle as a clear of that bit shows which side wins. The interrupt is driven up and down through the flag path and through the mask path. It is also checked with a masked stall flag, which must not raise it. The completion condition is tried with partial, full and noisy-upper-bit enable patterns. Writes and reads at another address, and writes to reserved bits, check that nothing else reaches the word.

// File: rtl/dma_irq_status_pkg.sv
package dma_irq_status_pkg;
   localparam int STAT_W       = 32;
   localparam int MAX_CH       = 10;
   localparam int STALL_FLAG   = 13;
   localparam int FEMPTY_FLAG  = 14;
   localparam int BUSERR_FLAG  = 15;
   localparam int MASK_BASE    = 16;
   localparam int STALL_MASK   = 29;
   localparam int FEMPTY_MASK  = 30;
   localparam int SPECIAL_FLAGS = 3;
   localparam int SPECIAL_MASKS = 2;

   function automatic logic [STAT_W-1:0] live_bits(input int nch);
      logic [STAT_W-1:0] v;
      v = '0;
      for (int i = 0; i < nch; i++) begin
         v[i]             = 1'b1;
         v[MASK_BASE + i] = 1'b1;
      end
      v[STALL_FLAG]  = 1'b1;
      v[FEMPTY_FLAG] = 1'b1;
      v[BUSERR_FLAG] = 1'b1;
      v[STALL_MASK]  = 1'b1;
      v[FEMPTY_MASK] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/dis_w1c_bank.sv
module dis_w1c_bank #(
   parameter int W = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("dis_w1c_bank: W must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q_o[i] <= 1'b0;
         else if (set_i[i])   q_o[i] <= 1'b1;
         else if (clr_i[i])   q_o[i] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q_o[i]); // R5

      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !q_o[i]); // R3

      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i])); // R2
   end
endmodule

// File: rtl/dis_toggle_bank.sv
module dis_toggle_bank #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] tgl_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("dis_toggle_bank: W must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_o[i] <= 1'b0;
         else if (tgl_i[i]) q_o[i] <= ~q_o[i];
      end

      AST_MASK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
         tgl_i[i] |=> (q_o[i] != $past(q_o[i]))); // R4

      AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !tgl_i[i] |=> $stable(q_o[i])); // R4
   end
endmodule

// File: rtl/dis_irq_eval.sv
module dis_irq_eval #(
   parameter int NUM_CH  = 10,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_flag_i,
   input  logic [NUM_CH-1:0] ch_mask_i,
   input  logic [NUM_CH-1:0] ch_en_i,
   output logic              irq_o,
   output logic              all_done_o
);
   logic [NUM_CH-1:0] pending;
   logic [NUM_CH-1:0] finished;
   logic              irq_raw;

   assign pending    = ch_flag_i & ch_mask_i;
   assign finished   = ch_flag_i | ~ch_en_i;
   assign irq_raw    = |pending;
   assign all_done_o = &finished;

   generate
      if (IRQ_REG) begin : g_irq_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= irq_raw;
         end
         AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mask_i == '0) |=> !irq_o); // R6
      end else begin : g_irq_comb
         assign irq_o = irq_raw;
         AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mask_i == '0) |-> !irq_o); // R6
      end
   endgenerate

   AST_DONE_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en_i == '0) |-> all_done_o); // R7
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
   import dma_irq_status_pkg::*;
#(
   parameter int              NUM_CH   = 10,
   parameter int              ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10,
   parameter bit              IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_we,
   output logic [31:0]       reg_rdata,
   input  logic [NUM_CH-1:0] ch_done_i,
   input  logic              stall_evt_i,
   input  logic              fifo_empty_evt_i,
   input  logic              bus_err_evt_i,
   input  logic [31:0]       pcr_i,
   output logic              irq_o,
   output logic              all_done_o
);
   localparam int FLAG_W = NUM_CH + SPECIAL_FLAGS;
   localparam int MASK_W = NUM_CH + SPECIAL_MASKS;
   localparam logic [STAT_W-1:0] LIVE = live_bits(NUM_CH);

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("dma_irq_status: NUM_CH must lie in 1..10");
      end
   endgenerate

   logic              wr_hit;
   logic [FLAG_W-1:0] flag_set, flag_clr, flag_q;
   logic [MASK_W-1:0] mask_tgl, mask_q;
   logic [STAT_W-1:0] status_word;
   logic              unused_inputs;

   assign wr_hit = reg_we && (reg_addr == REG_ADDR);

   assign flag_set = {bus_err_evt_i, fifo_empty_evt_i, stall_evt_i, ch_done_i};
   assign flag_clr = {FLAG_W{wr_hit}} &
                     {reg_wdata[BUSERR_FLAG], reg_wdata[FEMPTY_FLAG],
                      reg_wdata[STALL_FLAG], reg_wdata[NUM_CH-1:0]};
   assign mask_tgl = {MASK_W{wr_hit}} &
                     {reg_wdata[FEMPTY_MASK], reg_wdata[STALL_MASK],
                      reg_wdata[MASK_BASE +: NUM_CH]};

   assign unused_inputs = ^{reg_wdata[31], reg_wdata[28:MASK_BASE+NUM_CH],
                            reg_wdata[12:NUM_CH], pcr_i[31:NUM_CH]};

   dis_w1c_bank #(.W(FLAG_W)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set),
      .clr_i (flag_clr),
      .q_o   (flag_q)
   );

   dis_toggle_bank #(.W(MASK_W)) u_masks (
      .clk   (clk),
      .rst_n (rst_n),
      .tgl_i (mask_tgl),
      .q_o   (mask_q)
   );

   dis_irq_eval #(.NUM_CH(NUM_CH), .IRQ_REG(IRQ_REG)) u_eval (
      .clk        (clk),
      .rst_n      (rst_n),
      .ch_flag_i  (flag_q[NUM_CH-1:0]),
      .ch_mask_i  (mask_q[NUM_CH-1:0]),
      .ch_en_i    (pcr_i[NUM_CH-1:0]),
      .irq_o      (irq_o),
      .all_done_o (all_done_o)
   );

   always_comb begin
      status_word = '0;
      status_word[NUM_CH-1:0]           = flag_q[NUM_CH-1:0];
      status_word[STALL_FLAG]           = flag_q[NUM_CH];
      status_word[FEMPTY_FLAG]          = flag_q[NUM_CH+1];
      status_word[BUSERR_FLAG]          = flag_q[NUM_CH+2];
      status_word[MASK_BASE +: NUM_CH]  = mask_q[NUM_CH-1:0];
      status_word[STALL_MASK]           = mask_q[NUM_CH];
      status_word[FEMPTY_MASK]          = mask_q[NUM_CH+1];
   end

   assign reg_rdata = (reg_addr == REG_ADDR) ? status_word : '0;

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~LIVE) == '0); // R8

   AST_FOREIGN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != REG_ADDR) |-> (reg_rdata == '0)); // R9

   AST_SPECIAL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_word[NUM_CH-1:0] == '0) && !IRQ_REG) |-> !irq_o); // R10
endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_REG   = 8'h10;
   localparam logic [7:0] A_OTHER = 8'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = A_REG;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic [9:0]  ch_done_i = '0;
   logic        stall_evt_i = 1'b0;
   logic        fifo_empty_evt_i = 1'b0;
   logic        bus_err_evt_i = 1'b0;
   logic [31:0] pcr_i = '0;
   logic        irq_o;
   logic        all_done_o;

   int checks = 0;
   int fails  = 0;
   logic [31:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_irq_status u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .ch_done_i(ch_done_i),
      .stall_evt_i(stall_evt_i), .fifo_empty_evt_i(fifo_empty_evt_i),
      .bus_err_evt_i(bus_err_evt_i), .pcr_i(pcr_i), .irq_o(irq_o),
      .all_done_o(all_done_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus write, with optional same-cycle events; bench model follows R3/R4/R5/R8
   task automatic cycle_write(input logic [7:0] a, input logic [31:0] d,
                              input logic [9:0] ch, input logic [2:0] ev);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      ch_done_i = ch; {bus_err_evt_i, fifo_empty_evt_i, stall_evt_i} = ev;
      @(negedge clk);
      reg_we = 1'b0; ch_done_i = '0;
      {bus_err_evt_i, fifo_empty_evt_i, stall_evt_i} = '0;
      reg_addr = A_REG;
      if (a == A_REG) begin
         model[15:0]  = model[15:0] & ~(d[15:0] & 16'hE3FF);
         model[31:16] = model[31:16] ^ (d[31:16] & 16'h63FF);
      end
      model[9:0] = model[9:0] | ch;
      model[15:13] = model[15:13] | ev;
   endtask

   task automatic pulse(input logic [9:0] ch, input logic [2:0] ev);
      cycle_write(A_REG, 32'h0, ch, ev);
      // with we=0 path: redo as a non-write cycle
   endtask

   task automatic read_chk(input string req);
      reg_addr = A_REG;
      #1 check(req, reg_rdata, model);
   endtask

   task automatic t_reset;
      read_chk("R1");
      check("R1", {31'b0, irq_o}, 32'h0);
      pcr_i = '0; #1;
      check("R7", {31'b0, all_done_o}, 32'h1);
   endtask

   task automatic t_events;
      pulse(10'h201, 3'b001); // R2: channel 0, channel 9, stall -> bits 0,9,13
      read_chk("R2");
      check("R2", model, 32'h0000_2201);
      pulse(10'h000, 3'b100); // R2: bus error -> bit 15
      read_chk("R2");
      check("R2", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_clear;
      cycle_write(A_REG, 32'h0000_8001, '0, '0); // R3: clear bits 15 and 0
      read_chk("R3");
      check("R3", model, 32'h0000_2200);
   endtask

   task automatic t_mask_irq;
      cycle_write(A_REG, 32'h6200_0000, '0, '0); // R4: flip 30,29,25
      read_chk("R4");
      check("R4", model, 32'h6200_2200);
      check("R6", {31'b0, irq_o}, 32'h1);
      cycle_write(A_REG, 32'h4000_0000, '0, '0); // R4: flip 30 back off
      read_chk("R4");
      cycle_write(A_REG, 32'h0200_0000, '0, '0); // mask 25 off -> irq drops
      check("R6", {31'b0, irq_o}, 32'h0);
      cycle_write(A_REG, 32'h0200_0000, '0, '0); // mask on again
      check("R6", {31'b0, irq_o}, 32'h1);
      cycle_write(A_REG, 32'h0000_0200, '0, '0); // clear flag 9
      check("R6", {31'b0, irq_o}, 32'h0);
      // stall flag 13 with stall mask 29 set must not interrupt
      read_chk("R10");
      check("R10", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_collision;
      cycle_write(A_REG, 32'h0, 10'h010, '0);       // set channel 4
      cycle_write(A_REG, 32'h0000_0010, 10'h010, '0); // clear and set together
      read_chk("R5");
      check("R5", model & 32'h10, 32'h10);
   endtask

   task automatic t_done;
      pcr_i = 32'h0000_0011; #1;   // ch0 not done, ch4 done
      check("R7", {31'b0, all_done_o}, 32'h0);
      pulse(10'h001, '0);
      check("R7", {31'b0, all_done_o}, 32'h1);
      pcr_i = 32'hFFFF_0011; #1;
      check("R7", {31'b0, all_done_o}, 32'h1);
      pcr_i = 32'h0000_03FF; #1;
      check("R7", {31'b0, all_done_o}, 32'h0);
      pcr_i = '0;
   endtask

   task automatic t_reserved;
      cycle_write(A_REG, 32'h9C00_1C00, '0, '0);
      read_chk("R8");
      check("R8", reg_rdata & 32'h9C00_1C00, 32'h0);
   endtask

   task automatic t_foreign;
      cycle_write(A_OTHER, 32'hFFFF_FFFF, '0, '0);
      read_chk("R9");
      reg_addr = A_OTHER; #1;
      check("R9", reg_rdata, 32'h0);
      reg_addr = A_REG;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_events();
      t_clear();
      t_mask_irq();
      t_collision();
      t_done();
      t_reserved();
      t_foreign();
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule